// File: doc/BRIEF.md
# UART Channel Mode Router

This block sits between the host-facing data register of a UART, its receive and transmit FIFOs, and the serial line. A 2-bit channel mode chooses where each byte goes.

- **Normal:** line bytes go to the receive side and host writes go out on the transmit side.
- **Automatic echo:** every line byte is kept and also sent back out.
- **Local loopback:** host writes are turned back into the receive FIFO.
- **Remote loopback:** line bytes are sent straight back to the line and the host sees nothing.

A small control word gates each direction and can request a flush of either FIFO.

The block does not hold the FIFO storage. It takes each FIFO's free-space count as an input and returns registered push strobes with the byte to store. Towards the line receiver it reports how many bytes it can accept now. That figure is the smallest free count among the FIFOs that the current mode writes into.

Top module: `uart_mode_router`

## Requirements
- R1: After reset the control word holds 0x128, so both directions are disabled and no line byte or host data write causes a push. The mode is normal, and all strobe outputs are low.
- R2: A write to the mode register (address 1) loads the mode from write-data bits [9:8]: 0 normal, 1 echo, 2 local loopback, 3 remote loopback. A byte sampled in the same cycle as the mode write is routed under the old mode, and bytes from the next cycle onward use the new mode.
- R3: In normal mode, a line byte is pushed to the receive FIFO and a host data write (address 2, byte in bits [7:0]) is pushed to the transmit FIFO.
- R4: In echo mode, a line byte is pushed to both FIFOs, and a host data write causes no push.
- R5: In local loopback mode, a host data write is pushed to the receive FIFO, a line byte causes no push, and the line side is always ready.
- R6: In remote loopback mode, a line byte is pushed to the transmit FIFO only, and a host data write causes no push.
- R7: The line space output equals the minimum free count over the FIFOs the current mode writes from the line. When the mode writes neither FIFO, it equals the larger FIFO depth. The ready output is high exactly when this space is non-zero.
- R8: A transmit push attempted while the transmit free count is 0 is dropped, and the transmit overflow output pulses for one cycle instead.
- R9: A receive push attempted while the receive free count is 0 is dropped, and the receive overrun output pulses for one cycle instead.
- R10: Control word (address 0) bits:
  - The receive direction is on only while bit 2 is set and bit 3 is clear.
  - The transmit direction is on only while bit 4 is set and bit 5 is clear.
  - A push towards a direction that is off is dropped silently, with no overflow or overrun pulse.
- R11: A control write with bit 0 set pulses the receive flush output for one cycle, and a write with bit 1 set pulses the transmit flush output. Neither bit is retained.
- R12: Push strobes, overflow pulses and flush pulses appear in the cycle after their inputs are sampled, and the push data carries the routed byte while its strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Host register write strobe |
| regAddr | input | 2 | Register index: 0 control, 1 mode, 2 data |
| regWrData | input | REG_W | Host write data |
| lineValid | input | 1 | Byte from the line receiver is present |
| lineByte | input | DATA_W | Byte from the line receiver |
| rxFree | input | CNT_W | Free entries in the receive FIFO |
| txFree | input | CNT_W | Free entries in the transmit FIFO |
| lineSpace | output | CNT_W | Bytes the line receiver may deliver now |
| lineReady | output | 1 | Line side can accept a byte |
| rxPush | output | 1 | Push strobe to the receive FIFO |
| rxPushData | output | DATA_W | Byte for the receive FIFO |
| txPush | output | 1 | Push strobe to the transmit FIFO |
| txPushData | output | DATA_W | Byte for the transmit FIFO |
| rxOverrun | output | 1 | Receive push dropped because the FIFO is full |
| txOverflow | output | 1 | Transmit push dropped because the FIFO is full |
| rxFlush | output | 1 | One-cycle receive FIFO flush request |
| txFlush | output | 1 | One-cycle transmit FIFO flush request |

## Verification
A stale or wrong mode register shows up on the next byte as a push on the wrong FIFO, or a missing push. It also shows up at once on the line space output, because that output depends only on the mode and the free counts. A wrong enable state shows up one cycle after a host or line byte as a push that should have been dropped, or the reverse. The bench steps through every mode, with the free counts at zero and non-zero. It changes the mode in the same cycle as a line byte and then runs a randomized stretch. It compares all outputs against its reference model on every clock.

// File: rtl/uart_route_pkg.sv
`timescale 1ns/1ps
package uart_route_pkg;

  typedef enum logic [1:0] {
    CH_NORMAL = 2'd0,
    CH_ECHO   = 2'd1,
    CH_LOCAL  = 2'd2,
    CH_REMOTE = 2'd3
  } chanMode_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int MODE_LSB    = 8;
  localparam int CTRL_W      = 9;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 9'h128;

  localparam int BIT_RX_FLUSH = 0;
  localparam int BIT_TX_FLUSH = 1;
  localparam int BIT_RX_EN    = 2;
  localparam int BIT_RX_DIS   = 3;
  localparam int BIT_TX_EN    = 4;
  localparam int BIT_TX_DIS   = 5;

  // strobes from control to datapath
  typedef struct packed {
    chanMode_e mode;
    logic      rxOn;
    logic      txOn;
    logic      hostWr;
  } routeCtl_t;

  function automatic logic lineFeedsRx(chanMode_e m);
    return (m == CH_NORMAL) || (m == CH_ECHO);
  endfunction

  function automatic logic lineFeedsTx(chanMode_e m);
    return (m == CH_ECHO) || (m == CH_REMOTE);
  endfunction

endpackage

// File: rtl/uart_route_ctrl.sv
`timescale 1ns/1ps
module uart_route_ctrl
  import uart_route_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  output routeCtl_t        ctl,
  output logic             rxFlush,
  output logic             txFlush
);

  localparam logic [CTRL_W-1:0] SELF_CLEAR =
    CTRL_W'((1 << BIT_RX_FLUSH) | (1 << BIT_TX_FLUSH));

  logic [CTRL_W-1:0] ctrlReg;
  chanMode_e         modeReg;
  logic              ctrlWr;
  logic              modeWr;

  assign ctrlWr = regWrEn && (regAddr == ADDR_CTRL);
  assign modeWr = regWrEn && (regAddr == ADDR_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlReg <= CTRL_RESET;
      modeReg <= CH_NORMAL;
      rxFlush <= 1'b0;
      txFlush <= 1'b0;
    end else begin
      rxFlush <= ctrlWr && regWrData[BIT_RX_FLUSH];
      txFlush <= ctrlWr && regWrData[BIT_TX_FLUSH];
      if (ctrlWr) begin
        ctrlReg <= regWrData[CTRL_W-1:0] & ~SELF_CLEAR;
      end
      if (modeWr) begin
        modeReg <= chanMode_e'(regWrData[MODE_LSB+1:MODE_LSB]);
      end
    end
  end

  always_comb begin
    ctl.mode   = modeReg;
    ctl.rxOn   = ctrlReg[BIT_RX_EN] && !ctrlReg[BIT_RX_DIS];
    ctl.txOn   = ctrlReg[BIT_TX_EN] && !ctrlReg[BIT_TX_DIS];
    ctl.hostWr = regWrEn && (regAddr == ADDR_DATA);
  end

  // R11
  rx_flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxFlush |-> $past(regWrEn && regAddr == ADDR_CTRL && regWrData[BIT_RX_FLUSH]));

  // R11
  tx_flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txFlush |-> $past(regWrEn && regAddr == ADDR_CTRL && regWrData[BIT_TX_FLUSH]));

endmodule

// File: rtl/uart_push_gate.sv
`timescale 1ns/1ps
module uart_push_gate #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              want,
  input  logic              dirOn,
  input  logic [CNT_W-1:0]  free,
  input  logic [DATA_W-1:0] byteIn,
  output logic              push,
  output logic [DATA_W-1:0] pushData,
  output logic              full
);

  logic go;
  assign go = want && dirOn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push     <= 1'b0;
      pushData <= '0;
      full     <= 1'b0;
    end else begin
      push <= go && (free != '0);
      full <= go && (free == '0);
      if (go) pushData <= byteIn;
    end
  end

  // R8 R9
  push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> $past(free) != '0);

  // R8 R9
  full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full));

endmodule

// File: rtl/uart_route_datapath.sv
`timescale 1ns/1ps
module uart_route_datapath
  import uart_route_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 7,
  parameter int NONE_SPACE = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  routeCtl_t         ctl,
  input  logic [DATA_W-1:0] hostByte,
  input  logic              lineValid,
  input  logic [DATA_W-1:0] lineByte,
  input  logic [CNT_W-1:0]  rxFree,
  input  logic [CNT_W-1:0]  txFree,
  output logic [CNT_W-1:0]  lineSpace,
  output logic              lineReady,
  output logic              rxPush,
  output logic [DATA_W-1:0] rxPushData,
  output logic              txPush,
  output logic [DATA_W-1:0] txPushData,
  output logic              rxOverrun,
  output logic              txOverflow
);

  logic              feedRx, feedTx;
  logic              wantRx, wantTx;
  logic [DATA_W-1:0] rxByte, txByte;

  always_comb begin
    feedRx = lineFeedsRx(ctl.mode);
    feedTx = lineFeedsTx(ctl.mode);
    lineSpace = CNT_W'(NONE_SPACE);
    if (feedRx && rxFree < lineSpace) lineSpace = rxFree;
    if (feedTx && txFree < lineSpace) lineSpace = txFree;
  end

  assign lineReady = (lineSpace != '0);

  always_comb begin
    wantRx = (lineValid && feedRx) || (ctl.hostWr && ctl.mode == CH_LOCAL);
    wantTx = (lineValid && feedTx) || (ctl.hostWr && ctl.mode == CH_NORMAL);
    rxByte = (ctl.mode == CH_LOCAL)  ? hostByte : lineByte;
    txByte = (ctl.mode == CH_NORMAL) ? hostByte : lineByte;
  end

  uart_push_gate #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rxGate (
    .clk(clk), .rst_n(rst_n), .want(wantRx), .dirOn(ctl.rxOn),
    .free(rxFree), .byteIn(rxByte),
    .push(rxPush), .pushData(rxPushData), .full(rxOverrun)
  );

  uart_push_gate #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_txGate (
    .clk(clk), .rst_n(rst_n), .want(wantTx), .dirOn(ctl.txOn),
    .free(txFree), .byteIn(txByte),
    .push(txPush), .pushData(txPushData), .full(txOverflow)
  );

  // R6
  remote_no_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl.mode == CH_REMOTE) |-> !rxPush && !rxOverrun);

  // R4
  echo_host_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl.mode == CH_ECHO && !lineValid) |-> !rxPush && !txPush);

  // R5
  local_line_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl.mode == CH_LOCAL && !ctl.hostWr) |-> !rxPush && !txPush);

  // R5
  local_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.mode == CH_LOCAL) |-> lineReady);

  // R10
  rx_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ctl.rxOn) |-> !rxPush && !rxOverrun);

endmodule

// File: rtl/uart_mode_router.sv
`timescale 1ns/1ps
module uart_mode_router
  import uart_route_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int REG_W    = 32,
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 64,
  localparam int MAX_DEPTH = (RX_DEPTH > TX_DEPTH) ? RX_DEPTH : TX_DEPTH,
  localparam int CNT_W     = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              lineValid,
  input  logic [DATA_W-1:0] lineByte,
  input  logic [CNT_W-1:0]  rxFree,
  input  logic [CNT_W-1:0]  txFree,
  output logic [CNT_W-1:0]  lineSpace,
  output logic              lineReady,
  output logic              rxPush,
  output logic [DATA_W-1:0] rxPushData,
  output logic              txPush,
  output logic [DATA_W-1:0] txPushData,
  output logic              rxOverrun,
  output logic              txOverflow,
  output logic              rxFlush,
  output logic              txFlush
);

  routeCtl_t ctl;

  uart_route_ctrl #(.REG_W(REG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .ctl(ctl), .rxFlush(rxFlush), .txFlush(txFlush)
  );

  uart_route_datapath #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .NONE_SPACE(MAX_DEPTH)
  ) u_data (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .hostByte(regWrData[DATA_W-1:0]),
    .lineValid(lineValid), .lineByte(lineByte), .rxFree(rxFree), .txFree(txFree),
    .lineSpace(lineSpace), .lineReady(lineReady),
    .rxPush(rxPush), .rxPushData(rxPushData),
    .txPush(txPush), .txPushData(txPushData),
    .rxOverrun(rxOverrun), .txOverflow(txOverflow)
  );

endmodule

// File: tb/uart_mode_router_tb.sv
`timescale 1ns/1ps
module uart_mode_router_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = 32'd0;
  logic        lineValid = 1'b0;
  logic [7:0]  lineByte = 8'd0;
  logic [6:0]  rxFree = 7'd5;
  logic [6:0]  txFree = 7'd5;
  logic [6:0]  lineSpace;
  logic        lineReady, rxPush, txPush, rxOverrun, txOverflow, rxFlush, txFlush;
  logic [7:0]  rxPushData, txPushData;

  always #4 clk = ~clk;

  uart_mode_router u_dut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .lineValid(lineValid), .lineByte(lineByte),
    .rxFree(rxFree), .txFree(txFree), .lineSpace(lineSpace), .lineReady(lineReady),
    .rxPush(rxPush), .rxPushData(rxPushData), .txPush(txPush),
    .txPushData(txPushData), .rxOverrun(rxOverrun), .txOverflow(txOverflow),
    .rxFlush(rxFlush), .txFlush(txFlush)
  );

  int    errors = 0;
  int    checks = 0;
  bit    started = 0;
  bit    done = 0;
  string curTag = "R1";

  // reference model state
  int mCtrl = 'h128;
  int mMode = 0;
  bit eRxPush, eTxPush, eRxOvr, eTxOvr, eRxFl, eTxFl;
  int eRxData, eTxData;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", curTag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      mCtrl = 'h128; mMode = 0;
      eRxPush = 0; eTxPush = 0; eRxOvr = 0; eTxOvr = 0; eRxFl = 0; eTxFl = 0;
    end else begin
      bit rxOn, txOn, dataWr, wRx, wTx;
      int bRx, bTx;
      rxOn = mCtrl[2] && !mCtrl[3];
      txOn = mCtrl[4] && !mCtrl[5];
      dataWr = regWrEn && regAddr == 2;
      wRx = 0; wTx = 0; bRx = lineByte; bTx = lineByte;
      case (mMode)
        0: begin wRx = lineValid; wTx = dataWr; bTx = regWrData[7:0]; end
        1: begin wRx = lineValid; wTx = lineValid; end
        2: begin wRx = dataWr; bRx = regWrData[7:0]; end
        default: wTx = lineValid;
      endcase
      eRxPush = wRx && rxOn && rxFree != 0;
      eRxOvr  = wRx && rxOn && rxFree == 0;
      eTxPush = wTx && txOn && txFree != 0;
      eTxOvr  = wTx && txOn && txFree == 0;
      eRxData = bRx; eTxData = bTx;
      eRxFl = regWrEn && regAddr == 0 && regWrData[0];
      eTxFl = regWrEn && regAddr == 0 && regWrData[1];
      if (regWrEn && regAddr == 0) mCtrl = regWrData[8:0] & ~3;
      if (regWrEn && regAddr == 1) mMode = regWrData[9:8];
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      int sp;
      chk(rxPush == eRxPush, "rxPush", rxPush, eRxPush);
      chk(txPush == eTxPush, "txPush", txPush, eTxPush);
      chk(rxOverrun == eRxOvr, "rxOverrun", rxOverrun, eRxOvr);
      chk(txOverflow == eTxOvr, "txOverflow", txOverflow, eTxOvr);
      chk(rxFlush == eRxFl, "rxFlush", rxFlush, eRxFl);
      chk(txFlush == eTxFl, "txFlush", txFlush, eTxFl);
      if (eRxPush) chk(rxPushData == eRxData[7:0], "rxPushData", rxPushData, eRxData);
      if (eTxPush) chk(txPushData == eTxData[7:0], "txPushData", txPushData, eTxData);
      sp = 64;
      if ((mMode == 0 || mMode == 1) && rxFree < sp) sp = rxFree;
      if ((mMode == 1 || mMode == 3) && txFree < sp) sp = txFree;
      chk(lineSpace == sp, "lineSpace", lineSpace, sp);
      chk(lineReady == (sp != 0), "lineReady", lineReady, sp != 0);
    end
  end

  task automatic cyc(input logic wr, input logic [1:0] a, input logic [31:0] d,
                     input logic lv, input logic [7:0] lb);
    @(posedge clk); #2;
    regWrEn = wr; regAddr = a; regWrData = d; lineValid = lv; lineByte = lb;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic setMode(input int m);
    cyc(1, 1, m << 8, 0, 0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset values, then everything disabled
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    curTag = "R1";
    cyc(0, 2, 32'h41, 1, 8'h11);
    cyc(1, 2, 32'h42, 1, 8'h12);
    idle(2);

    // R10: enable both directions
    curTag = "R10";
    cyc(1, 0, 32'h14, 0, 0);
    // R3 normal mode routing
    curTag = "R3";
    cyc(0, 0, 0, 1, 8'hA1);
    cyc(1, 2, 32'hB2, 0, 0);
    cyc(1, 2, 32'hC3, 1, 8'hD4);
    idle(1);

    // R11 flushes
    curTag = "R11";
    cyc(1, 0, 32'h17, 0, 0);
    cyc(1, 0, 32'h16, 0, 0);
    cyc(1, 0, 32'h15, 0, 0);
    idle(2);

    // R4 echo
    curTag = "R4";
    setMode(1);
    cyc(0, 0, 0, 1, 8'h5A);
    cyc(1, 2, 32'h77, 0, 0);
    rxFree = 7'd2; txFree = 7'd9;
    cyc(0, 0, 0, 1, 8'h6B);
    idle(1);

    // R2 mode change with byte in same cycle (echo -> remote)
    curTag = "R2";
    cyc(1, 1, 32'h300, 1, 8'h3C);
    cyc(0, 0, 0, 1, 8'h4D);
    idle(1);

    // R6 remote
    curTag = "R6";
    cyc(1, 2, 32'h99, 0, 0);
    cyc(0, 0, 0, 1, 8'hE6);
    idle(1);

    // R5 local loopback
    curTag = "R5";
    setMode(2);
    rxFree = 7'd0; txFree = 7'd0;
    cyc(0, 0, 0, 1, 8'h01);
    rxFree = 7'd3;
    cyc(1, 2, 32'hF5, 0, 0);
    idle(1);

    // R7 space in each mode
    curTag = "R7";
    for (int m = 0; m < 4; m++) begin
      setMode(m);
      rxFree = 7'd7; txFree = 7'd3; idle(1);
      rxFree = 7'd0; txFree = 7'd64; idle(1);
      rxFree = 7'd64; txFree = 7'd0; idle(1);
    end

    // R8 tx full
    curTag = "R8";
    setMode(0);
    rxFree = 7'd4; txFree = 7'd0;
    cyc(1, 2, 32'h88, 0, 0);
    setMode(3);
    cyc(0, 0, 0, 1, 8'h89);
    idle(1);

    // R9 rx full
    curTag = "R9";
    setMode(0);
    rxFree = 7'd0; txFree = 7'd4;
    cyc(0, 0, 0, 1, 8'h90);
    setMode(2);
    cyc(1, 2, 32'h91, 0, 0);
    idle(1);

    // R10 disable bits override enable: silent drop even when full
    curTag = "R10";
    setMode(1);
    cyc(1, 0, 32'h3C, 0, 0);
    cyc(0, 0, 0, 1, 8'hAA);
    rxFree = 7'd4; txFree = 7'd4;
    cyc(1, 0, 32'h1C, 0, 0);
    cyc(0, 0, 0, 1, 8'hAB);
    cyc(1, 0, 32'h34, 0, 0);
    cyc(0, 0, 0, 1, 8'hAC);
    idle(1);

    // R12 random traffic
    curTag = "R12";
    for (int i = 0; i < 600; i++) begin
      logic [1:0] a;
      logic [31:0] d;
      a = 2'($urandom_range(0, 3));
      d = $urandom;
      if (a == 0) d = {23'd0, 3'b000, 1'b0, d[4:2], 1'b0, d[1:0]} | 32'h14;
      if (($urandom % 8) == 0) d[5] = 1'b1;
      rxFree = 7'($urandom_range(0, 3));
      txFree = 7'($urandom_range(0, 3));
      cyc(($urandom % 3) == 0, a, d, $urandom % 2, 8'($urandom));
    end
    idle(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule